// File: doc/BRIEF.md
# Keyboard-Capable General-Purpose Port

This block is an eight-line bidirectional port that a simple CPU bus reaches through three byte-wide registers. A value register holds the levels the port drives. A direction register chooses, pin by pin, whether the line is driven or only sensed. A control/status byte arms a key-scan feature. While key scan is armed, every line that is an input gets a pull-up. The block watches the combined level of those lines and latches an interrupt when that level drops, which is how a pressed key is detected. The latched flag stays until software writes a one to clear it.

A mode input lets an external bus take over the pins. While it is high, the port drives nothing, enables no pull-ups and raises no new key interrupt. It also stops decoding the value and direction addresses. An access to either address then raises a forward strobe, so the external bus logic can serve it. The output drivers take the value register directly. Software can therefore load the value first and then turn the pin to output, and the pin shows no glitch. Input levels pass through a two-flop synchronizer before read-back and before the interrupt logic.

Top module: `kbd_gpio_port`

## Requirements
- R1: The value register is at address 0x03, the direction register at 0x07 and the control/status byte at 0x0A. In the control/status byte, bit 0 is the key-scan arm bit (read/write), bit 1 is the interrupt flag (read-only), and bit 2 is a clear strobe (a write of 1 clears the flag; it reads as 0). A read of any other address returns 0.
- R2: Reset clears the direction register and the control/status byte. Reset leaves the value register unchanged.
- R3: Outside external-bus mode, `pin_oe[i]` equals direction bit i, where 1 means output.
- R4: `pin_out` always shows the value register, whatever the direction bits hold.
- R5: A read of the value register returns the register bit for output pins and the synchronized pin level for input pins. A pin change is visible in the read two clock edges after it is sampled.
- R6: `pin_pu[i]` is 1 exactly when the arm bit is set, pin i is an input, and the block is not in external-bus mode.
- R7: The interrupt flag is set when the AND of all armed input lines changes from 1 to 0. A line that is an output never sets the flag, and nothing sets it while the arm bit is clear.
- R8: Once set, the flag and `kbd_irq` stay high until a control/status write with bit 2 = 1. If a new falling edge arrives in the same cycle as the clear, the set wins.
- R9: While `ext_mode` is 1, accesses to 0x03 and 0x07 leave both registers unchanged and read 0, and `ext_req` is high for them. `pin_oe` and `pin_pu` are all zero, and no new interrupt is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_mode | input | 1 | 1 hands the pins and the value/direction addresses to an external bus |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational |
| ext_req | output | 1 | Access to a handed-over address must go to the external bus |
| pin_in | input | 8 | Pad input levels |
| pin_out | output | 8 | Pad output levels |
| pin_oe | output | 8 | Pad output enables |
| pin_pu | output | 8 | Pad pull-up enables |
| kbd_irq | output | 1 | Key-scan interrupt request |

## Verification
Random rounds draw a direction byte, a value byte and a pin pattern, then compare the read-back, the output enables and the pull-ups against a model that merges them per bit. These rounds show whether each bit's source in the read-back is chosen by its own direction bit. Directed key patterns test the interrupt in four ways. A low level on an output line must not set the flag, and a low level on an input line must. A clear while the key is still held must leave the flag low. Low lines must be ignored when the arm bit is clear or when the block is in external-bus mode. Reset and mode cases check that the value register survives reset and that accesses in external-bus mode go to the external bus.

// File: rtl/kbd_gpio_pkg.sv
package kbd_gpio_pkg;
  localparam int unsigned CSR_ARM_BIT = 0;
  localparam int unsigned CSR_FLAG_BIT = 1;
  localparam int unsigned CSR_CLR_BIT = 2;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_VAL  = 2'd1,
    SEL_DIR  = 2'd2,
    SEL_CSR  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/kbd_rst_sync.sv
module kbd_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/kbd_pin_sync.sv
module kbd_pin_sync #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pin_raw,
  output logic [WIDTH-1:0] pin_sync
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic meta_q, stab_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= 1'b1;
        stab_q <= 1'b1;
      end else begin
        meta_q <= pin_raw[i];
        stab_q <= meta_q;
      end
    end
    assign pin_sync[i] = stab_q;
  end
endmodule

// File: rtl/kbd_detect.sv
module kbd_detect #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pin_sync,
  input  logic [WIDTH-1:0] dir,
  input  logic             arm,
  input  logic             clr,
  output logic             flag
);
  logic [WIDTH-1:0] line_view;
  logic             level, level_q;
  logic             fall;
  logic             flag_d, flag_q;

  for (genvar i = 0; i < WIDTH; i++) begin : g_mask
    assign line_view[i] = pin_sync[i] | dir[i] | ~arm;
  end

  always_comb begin
    level  = &line_view;
    fall   = level_q & ~level;
    flag_d = flag_q;
    if (clr)  flag_d = 1'b0;
    if (fall) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= 1'b1;
      flag_q  <= 1'b0;
    end else begin
      level_q <= level;
      flag_q  <= flag_d;
    end
  end

  assign flag = flag_q;
endmodule

// File: rtl/kbd_gpio_port.sv
module kbd_gpio_port
  import kbd_gpio_pkg::*;
#(
  parameter int unsigned WIDTH     = 8,
  parameter int unsigned ADDR_W    = 8,
  parameter logic [7:0]  VAL_ADDR  = 8'h03,
  parameter logic [7:0]  DIR_ADDR  = 8'h07,
  parameter logic [7:0]  CSR_ADDR  = 8'h0A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_mode,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WIDTH-1:0]  bus_wdata,
  output logic [WIDTH-1:0]  bus_rdata,
  output logic              ext_req,
  input  logic [WIDTH-1:0]  pin_in,
  output logic [WIDTH-1:0]  pin_out,
  output logic [WIDTH-1:0]  pin_oe,
  output logic [WIDTH-1:0]  pin_pu,
  output logic              kbd_irq
);
  localparam int unsigned CSR_PAD = WIDTH - 3;

  logic             rst_sync_n;
  logic [WIDTH-1:0] val_q, val_d;
  logic [WIDTH-1:0] dir_q, dir_d;
  logic             ksen_q, ksen_d;
  logic             val_en, dir_en, csr_en;
  logic             clr_pulse;
  logic             port_live;
  logic [WIDTH-1:0] pin_sync;
  logic             flag;
  reg_sel_e         sel;

  kbd_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  kbd_pin_sync #(.WIDTH(WIDTH)) i_pin_sync (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .pin_raw  (pin_in),
    .pin_sync (pin_sync)
  );

  // Address decode: value and direction addresses vanish in external-bus mode
  always_comb begin
    sel = SEL_NONE;
    if (bus_sel) begin
      if (bus_addr == ADDR_W'(CSR_ADDR))                   sel = SEL_CSR;
      else if (!ext_mode && bus_addr == ADDR_W'(VAL_ADDR)) sel = SEL_VAL;
      else if (!ext_mode && bus_addr == ADDR_W'(DIR_ADDR)) sel = SEL_DIR;
    end
  end

  assign ext_req = bus_sel & ext_mode &
                   ((bus_addr == ADDR_W'(VAL_ADDR)) | (bus_addr == ADDR_W'(DIR_ADDR)));

  // Next-state logic with explicit clock enables
  always_comb begin
    val_en    = bus_wr & (sel == SEL_VAL);
    dir_en    = bus_wr & (sel == SEL_DIR);
    csr_en    = bus_wr & (sel == SEL_CSR);
    val_d     = val_en ? bus_wdata : val_q;
    dir_d     = dir_en ? bus_wdata : dir_q;
    ksen_d    = csr_en ? bus_wdata[CSR_ARM_BIT] : ksen_q;
    clr_pulse = csr_en & bus_wdata[CSR_CLR_BIT];
  end

  // Value register: not reset, keeps its content across reset
  always_ff @(posedge clk) begin
    val_q <= val_d;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      dir_q  <= '0;
      ksen_q <= 1'b0;
    end else begin
      dir_q  <= dir_d;
      ksen_q <= ksen_d;
    end
  end

  assign port_live = ~ext_mode;

  kbd_detect #(.WIDTH(WIDTH)) i_detect (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .pin_sync (pin_sync),
    .dir      (dir_q),
    .arm      (ksen_q & port_live),
    .clr      (clr_pulse),
    .flag     (flag)
  );

  // Pad controls
  assign pin_out = val_q;
  for (genvar i = 0; i < WIDTH; i++) begin : g_pad
    assign pin_oe[i] = dir_q[i] & port_live;
    assign pin_pu[i] = ksen_q & ~dir_q[i] & port_live;
  end
  assign kbd_irq = flag;

  // Read-back mux
  always_comb begin
    unique case (sel)
      SEL_VAL: bus_rdata = (dir_q & val_q) | (~dir_q & pin_sync);
      SEL_DIR: bus_rdata = dir_q;
      SEL_CSR: bus_rdata = {{CSR_PAD{1'b0}}, 1'b0, flag, ksen_q};
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/kbd_gpio_port_chk.sv
module kbd_gpio_port_chk #(
  parameter int unsigned WIDTH    = 8,
  parameter int unsigned ADDR_W   = 8,
  parameter logic [7:0]  DIR_ADDR = 8'h07,
  parameter logic [7:0]  CSR_ADDR = 8'h0A
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ext_mode,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [WIDTH-1:0]  bus_wdata,
  input logic              ext_req,
  input logic [WIDTH-1:0]  pin_oe,
  input logic [WIDTH-1:0]  pin_pu,
  input logic              kbd_irq,
  input logic              ksen_q
);
  logic csr_clr_wr, dir_wr;
  assign csr_clr_wr = bus_sel & bus_wr & (bus_addr == ADDR_W'(CSR_ADDR)) & bus_wdata[2];
  assign dir_wr     = bus_sel & bus_wr & ~ext_mode & (bus_addr == ADDR_W'(DIR_ADDR));

  AST_PAD_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_pu & pin_oe) == '0); // R6
  AST_EXT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    ext_mode |-> (pin_oe == '0 && pin_pu == '0)); // R9
  AST_EXT_FWD: assert property (@(posedge clk) disable iff (!rst_n)
    ext_req |-> (ext_mode && bus_sel)); // R9
  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (kbd_irq && !csr_clr_wr) |=> kbd_irq); // R8
  AST_FLAG_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(kbd_irq) |-> ($past(ksen_q) && !$past(ext_mode))); // R7
  AST_DIR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_wr && !ext_mode) |=> (ext_mode || pin_oe == $past(bus_wdata))); // R3
endmodule

bind kbd_gpio_port kbd_gpio_port_chk #(
  .WIDTH(WIDTH), .ADDR_W(ADDR_W), .DIR_ADDR(DIR_ADDR), .CSR_ADDR(CSR_ADDR)
) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ext_mode  (ext_mode),
  .bus_sel   (bus_sel),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .ext_req   (ext_req),
  .pin_oe    (pin_oe),
  .pin_pu    (pin_pu),
  .kbd_irq   (kbd_irq),
  .ksen_q    (ksen_q)
);

// File: tb/test_kbd_gpio_port.sv
module test_kbd_gpio_port;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       ext_mode;
  logic       bus_sel, bus_wr;
  logic [7:0] bus_addr, bus_wdata, bus_rdata;
  logic       ext_req;
  logic [7:0] pin_in, pin_out, pin_oe, pin_pu;
  logic       kbd_irq;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  localparam logic [7:0] A_VAL = 8'h03;
  localparam logic [7:0] A_DIR = 8'h07;
  localparam logic [7:0] A_CSR = 8'h0A;

  always #2 clk = ~clk;

  kbd_gpio_port i_kbd_gpio_port (
    .clk(clk), .rst_n(rst_n), .ext_mode(ext_mode),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_req(ext_req),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .pin_pu(pin_pu),
    .kbd_irq(kbd_irq)
  );

  function automatic logic [7:0] exp_read(input logic [7:0] dir, input logic [7:0] val,
                                          input logic [7:0] pins);
    return (dir & val) | (~dir & pins);
  endfunction

  function automatic logic [7:0] exp_pu(input logic ksen, input logic [7:0] dir,
                                        input logic ext);
    return (ksen && !ext) ? ~dir : 8'h00;
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(4);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    logic [7:0] dir, val, pins;
    logic       ksen;
    void'($urandom(32'd1234));
    ext_mode = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0;
    bus_addr = '0; bus_wdata = '0; pin_in = 8'hFF;
    do_reset();

    // Reset state
    bus_read(A_DIR, rd); check("R2 dir after reset", rd, 8'h00);
    bus_read(A_CSR, rd); check("R2 csr after reset", rd, 8'h00);
    check("R3 oe after reset", pin_oe, 8'h00);
    bus_read(8'h11, rd); check("R1 unmapped read", rd, 8'h00);

    // Value written before direction: output appears immediately
    bus_write(A_VAL, 8'hA5);
    check("R4 out follows value while input", pin_out, 8'hA5);
    bus_write(A_DIR, 8'hF0);
    check("R3 oe follows dir", pin_oe, 8'hF0);
    check("R4 out unchanged on dir write", pin_out, 8'hA5);
    pin_in = 8'h3C; idle(3);
    bus_read(A_VAL, rd); check("R5 mixed read", rd, exp_read(8'hF0, 8'hA5, 8'h3C));

    // Value register survives reset, direction is cleared
    do_reset();
    check("R3 oe cleared by reset", pin_oe, 8'h00);
    bus_write(A_DIR, 8'hFF);
    bus_read(A_VAL, rd); check("R2 value kept over reset", rd, 8'hA5);

    // Random rounds
    for (int k = 0; k < 150; k++) begin
      dir = 8'($urandom); val = 8'($urandom); pins = 8'($urandom); ksen = 1'($urandom);
      bus_write(A_VAL, val);
      bus_write(A_DIR, dir);
      bus_write(A_CSR, {5'b0, 1'b1, 1'b0, ksen});
      pin_in = pins; idle(3);
      bus_read(A_VAL, rd); check("R5 random read", rd, exp_read(dir, val, pins));
      check("R3 random oe", pin_oe, dir);
      check("R4 random out", pin_out, val);
      check("R6 random pu", pin_pu, exp_pu(ksen, dir, 1'b0));
      bus_read(A_DIR, rd); check("R1 dir read", rd, dir);
      bus_read(A_CSR, rd); check("R1 csr arm read", {7'b0, rd[0]}, {7'b0, ksen});
    end

    // Interrupt: low 4 lines are outputs
    pin_in = 8'hFF;
    bus_write(A_DIR, 8'h0F);
    bus_write(A_CSR, 8'h05);
    idle(4);
    bus_write(A_CSR, 8'h05);
    check("R8 flag cleared", {7'b0, kbd_irq}, 8'h00);
    pin_in = 8'hFD; idle(5);
    check("R7 output line ignored", {7'b0, kbd_irq}, 8'h00);
    pin_in = 8'hDF; idle(5);
    check("R7 input line low sets flag", {7'b0, kbd_irq}, 8'h01);
    bus_read(A_CSR, rd); check("R1 flag in csr bit1", rd, 8'h03);
    pin_in = 8'hFF; idle(5);
    check("R8 flag held after release", {7'b0, kbd_irq}, 8'h01);
    pin_in = 8'h7F; idle(5);
    bus_write(A_CSR, 8'h05); idle(3);
    check("R8 clear with key held", {7'b0, kbd_irq}, 8'h00);
    pin_in = 8'hFF; idle(4);

    // Disarmed: no interrupt
    bus_write(A_CSR, 8'h04);
    check("R6 pu off when disarmed", pin_pu, 8'h00);
    pin_in = 8'h00; idle(5);
    check("R7 disarmed ignores low", {7'b0, kbd_irq}, 8'h00);
    pin_in = 8'hFF; idle(4);

    // External-bus mode
    bus_write(A_CSR, 8'h01);
    bus_write(A_VAL, 8'h5A);
    ext_mode = 1'b1; idle(1);
    check("R9 oe released", pin_oe, 8'h00);
    check("R9 pu released", pin_pu, 8'h00);
    pin_in = 8'h00; idle(5);
    check("R9 no interrupt in ext mode", {7'b0, kbd_irq}, 8'h00);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = A_VAL; bus_wdata = 8'h11;
    #1 check("R9 ext_req on value addr", {7'b0, ext_req}, 8'h01);
    @(negedge clk);
    bus_addr = A_DIR; bus_wdata = 8'hFF;
    #1 check("R9 ext_req on dir addr", {7'b0, ext_req}, 8'h01);
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
    bus_read(A_VAL, rd); check("R9 value addr reads 0", rd, 8'h00);
    check("R9 value write ignored", pin_out, 8'h5A);
    pin_in = 8'hFF; idle(4);
    ext_mode = 1'b0; idle(1);
    check("R9 dir write ignored", pin_oe, 8'h0F);
    check("R9 no ext_req when idle", {7'b0, ext_req}, 8'h00);

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule